// File: doc/BRIEF.md
# Memoization Cache with Order-Insensitive Lookup

This block keeps the results of earlier evaluations of a single function so that a repeated call can be answered from storage instead of being recomputed. Each stored entry holds the complete set of operand values together with the result they produced. A lookup compares its operands against every entry in parallel and returns either a hit with the stored result or a miss.

Several requesters share one instance. A round-robin arbiter admits one lookup at a time, and the response carries the identifier of the requester it belongs to. A separate update channel installs a computed result. An update whose operands already match an entry rewrites that entry. Any other update fills the slot named by a rotating victim pointer.

Two static configuration inputs describe the function: its operand count, and whether it is commutative. When the function is commutative and takes two operands, a lookup that misses is searched a second time with the two operands exchanged. Only one operand order therefore needs to be stored.

Top module: `memo_cache`

## Requirements
- R1: After reset, `rsp_valid_o` and every bit of `req_ready_o` are low, and the store is empty, so the first lookup misses.
- R2: At most one `req_ready_o` bit is high, and only for a requester whose `req_valid_i` is high. When several requesters wait, they are granted in rotating order, starting from the index just after the last grant.
- R3: For a lookup that needs no second search, `rsp_valid_o` pulses for one cycle two clock edges after the accepting edge. On a hit, `rsp_hit_o` is 1 and `rsp_res_o` is the stored result.
- R4: On a miss, `rsp_hit_o` is 0 and `rsp_res_o` is 0.
- R5: Operand k occupies bits [k*DATA_W +: DATA_W] of an operand vector. `cfg_arity_i` holds the operand count minus one. Operands above that count take no part in matching.
- R6: With `cfg_commut_i`=1 and `cfg_arity_i`=1, a lookup that misses on (a,b) is searched again as (b,a). Its response arrives three edges after acceptance, either as a hit or as a miss.
- R7: With `cfg_commut_i`=1 but any other operand count, no second search is made, and the response timing of R3 applies.
- R8: With `cfg_commut_i`=0, a lookup whose operands are the stored ones in exchanged order misses.
- R9: An update whose operands match a valid entry rewrites that entry's result and consumes no new slot.
- R10: With `cfg_commut_i`=1 and `cfg_arity_i`=1, an update on (b,a) rewrites an entry stored as (a,b). The entry then holds the update's operand order.
- R11: Updates that match no entry fill slots in order. Once every slot is full, each such update replaces the oldest-filled slot.
- R12: `rsp_id_o` is the index of the requester whose lookup produced the response.
- R13: From the accepting edge until the response edge, no `req_ready_o` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_commut_i | input | 1 | Function is commutative |
| cfg_arity_i | input | $clog2(NUM_OPS) | Operand count minus one |
| req_valid_i | input | NUM_REQ | Lookup request per requester |
| req_ops_i | input | NUM_REQ*NUM_OPS*DATA_W | Operands per requester, requester r at slice r |
| req_ready_o | output | NUM_REQ | Lookup accepted this cycle |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | Result found |
| rsp_res_o | output | DATA_W | Stored result, 0 on miss |
| rsp_id_o | output | $clog2(NUM_REQ) | Requester of this response |
| upd_valid_i | input | 1 | Install a result |
| upd_ops_i | input | NUM_OPS*DATA_W | Operands of the result |
| upd_res_i | input | DATA_W | Computed result |

## Verification
A lookup is accepted at the clock edge where its ready bit is high. The first compare runs in the following cycle. The response is registered at the next edge, which is two edges after acceptance. An exchanged-order retry adds one more edge, for three. The driver records the cycle count at acceptance and pushes the expected response with its due cycle. The monitor compares hit, result, identifier and arrival cycle together, and it flags a response that has not arrived by its due cycle. An update takes effect at the edge after it is presented, and the next lookup is only presented after that edge.

// File: rtl/memo_pkg.sv
package memo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_SWP  = 2'd2
  } look_st_e;
endpackage

// File: rtl/memo_rr_arb.sv
module memo_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;
  logic          found;
  int            cand;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    cand  = 0;
    for (int k = 0; k < N; k++) begin
      cand = (int'(ptr_q) + k) % N;
      if (!found && en_i && req_i[cand]) begin
        found       = 1'b1;
        gnt_o[cand] = 1'b1;
        idx_o       = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (found) begin
      ptr_q <= (idx_o == IW'(N - 1)) ? '0 : idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/memo_match.sv
module memo_match #(
  parameter int NE = 8,
  parameter int NO = 4,
  parameter int DW = 16,
  localparam int EW  = (NE > 1) ? $clog2(NE) : 1,
  localparam int AW  = (NO > 1) ? $clog2(NO) : 1,
  localparam int OPW = NO * DW
) (
  input  logic [OPW-1:0]    key_i,
  input  logic [AW-1:0]     arity_i,
  input  logic [NE*OPW-1:0] ent_ops_i,
  input  logic [NE-1:0]     ent_vld_i,
  output logic              any_o,
  output logic [EW-1:0]     idx_o
);
  logic [NE-1:0] hit;

  for (genvar e = 0; e < NE; e++) begin : g_ent
    logic h;
    always_comb begin
      h = ent_vld_i[e];
      for (int j = 0; j < NO; j++) begin
        // operands above the configured count are ignored
        if (AW'(j) <= arity_i &&
            ent_ops_i[e*OPW + j*DW +: DW] != key_i[j*DW +: DW]) begin
          h = 1'b0;
        end
      end
    end
    assign hit[e] = h;
  end

  always_comb begin
    any_o = |hit;
    idx_o = '0;
    for (int e = NE - 1; e >= 0; e--) begin
      if (hit[e]) idx_o = EW'(e);
    end
  end
endmodule

// File: rtl/memo_store.sv
module memo_store #(
  parameter int NE = 8,
  parameter int NO = 4,
  parameter int DW = 16,
  localparam int EW  = (NE > 1) ? $clog2(NE) : 1,
  localparam int OPW = NO * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_hit_i,
  input  logic [EW-1:0]     wr_hit_idx_i,
  input  logic [OPW-1:0]    wr_ops_i,
  input  logic [DW-1:0]     wr_res_i,
  output logic [NE*OPW-1:0] ent_ops_o,
  output logic [NE*DW-1:0]  ent_res_o,
  output logic [NE-1:0]     ent_vld_o
);
  logic [OPW-1:0] ops_q [NE];
  logic [DW-1:0]  res_q [NE];
  logic [NE-1:0]  vld_q;
  logic [EW-1:0]  vic_q;
  logic [EW-1:0]  widx;

  assign widx = wr_hit_i ? wr_hit_idx_i : vic_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      vic_q <= '0;
      for (int e = 0; e < NE; e++) begin
        ops_q[e] <= '0;
        res_q[e] <= '0;
      end
    end else if (wr_en_i) begin
      ops_q[widx] <= wr_ops_i;
      res_q[widx] <= wr_res_i;
      vld_q[widx] <= 1'b1;
      // the victim pointer only moves on a fresh insert
      if (!wr_hit_i) vic_q <= (vic_q == EW'(NE - 1)) ? '0 : vic_q + 1'b1;
    end
  end

  for (genvar e = 0; e < NE; e++) begin : g_out
    assign ent_ops_o[e*OPW +: OPW] = ops_q[e];
    assign ent_res_o[e*DW +: DW]   = res_q[e];
  end
  assign ent_vld_o = vld_q;
endmodule

// File: rtl/memo_cache.sv
module memo_cache
  import memo_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int NUM_OPS = 4,
  parameter int DATA_W  = 16,
  parameter int NUM_ENT = 8,
  localparam int RW  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int AW  = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1,
  localparam int EW  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int OPW = NUM_OPS * DATA_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_commut_i,
  input  logic [AW-1:0]          cfg_arity_i,
  input  logic [NUM_REQ-1:0]     req_valid_i,
  input  logic [NUM_REQ*OPW-1:0] req_ops_i,
  output logic [NUM_REQ-1:0]     req_ready_o,
  output logic                   rsp_valid_o,
  output logic                   rsp_hit_o,
  output logic [DATA_W-1:0]      rsp_res_o,
  output logic [RW-1:0]          rsp_id_o,
  input  logic                   upd_valid_i,
  input  logic [OPW-1:0]         upd_ops_i,
  input  logic [DATA_W-1:0]      upd_res_i
);
  look_st_e st_q, st_d;
  logic [OPW-1:0]  pend_ops_q, key;
  logic [RW-1:0]   pend_id_q, g_idx;
  logic [NUM_REQ-1:0] gnt;
  logic            accept, can_swap, respond;
  logic            l_any, d_any, s_any, upd_hit;
  logic [EW-1:0]   l_idx, d_idx, s_idx, upd_idx;
  logic [OPW-1:0]  upd_swp;
  logic [NUM_ENT*OPW-1:0]    ent_ops;
  logic [NUM_ENT*DATA_W-1:0] ent_res;
  logic [NUM_ENT-1:0]        ent_vld;
  logic [DATA_W-1:0]         l_res;
  logic            rsp_valid_q, rsp_hit_q;
  logic [DATA_W-1:0] rsp_res_q;
  logic [RW-1:0]   rsp_id_q;

  assign can_swap = cfg_commut_i && (cfg_arity_i == AW'(1));

  memo_rr_arb #(.N(NUM_REQ)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st_q == ST_IDLE),
    .req_i  (req_valid_i),
    .gnt_o  (gnt),
    .idx_o  (g_idx)
  );
  assign req_ready_o = gnt;
  assign accept      = |gnt;

  // second pass exchanges operands 0 and 1
  always_comb begin
    key = pend_ops_q;
    if (st_q == ST_SWP) begin
      key[0 +: DATA_W]      = pend_ops_q[DATA_W +: DATA_W];
      key[DATA_W +: DATA_W] = pend_ops_q[0 +: DATA_W];
    end
    upd_swp = upd_ops_i;
    upd_swp[0 +: DATA_W]      = upd_ops_i[DATA_W +: DATA_W];
    upd_swp[DATA_W +: DATA_W] = upd_ops_i[0 +: DATA_W];
  end

  memo_match #(.NE(NUM_ENT), .NO(NUM_OPS), .DW(DATA_W)) u_look (
    .key_i     (key),
    .arity_i   (cfg_arity_i),
    .ent_ops_i (ent_ops),
    .ent_vld_i (ent_vld),
    .any_o     (l_any),
    .idx_o     (l_idx)
  );

  memo_match #(.NE(NUM_ENT), .NO(NUM_OPS), .DW(DATA_W)) u_upd_dir (
    .key_i     (upd_ops_i),
    .arity_i   (cfg_arity_i),
    .ent_ops_i (ent_ops),
    .ent_vld_i (ent_vld),
    .any_o     (d_any),
    .idx_o     (d_idx)
  );

  memo_match #(.NE(NUM_ENT), .NO(NUM_OPS), .DW(DATA_W)) u_upd_swp (
    .key_i     (upd_swp),
    .arity_i   (cfg_arity_i),
    .ent_ops_i (ent_ops),
    .ent_vld_i (ent_vld),
    .any_o     (s_any),
    .idx_o     (s_idx)
  );

  assign upd_hit = d_any || (can_swap && s_any);
  assign upd_idx = d_any ? d_idx : s_idx;

  memo_store #(.NE(NUM_ENT), .NO(NUM_OPS), .DW(DATA_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (upd_valid_i),
    .wr_hit_i     (upd_hit),
    .wr_hit_idx_i (upd_idx),
    .wr_ops_i     (upd_ops_i),
    .wr_res_i     (upd_res_i),
    .ent_ops_o    (ent_ops),
    .ent_res_o    (ent_res),
    .ent_vld_o    (ent_vld)
  );

  assign l_res = ent_res[l_idx*DATA_W +: DATA_W];

  always_comb begin
    st_d    = st_q;
    respond = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_FWD;
      ST_FWD: begin
        if (l_any || !can_swap) begin
          respond = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          st_d = ST_SWP;
        end
      end
      ST_SWP: begin
        respond = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pend_ops_q  <= '0;
      pend_id_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_res_q   <= '0;
      rsp_id_q    <= '0;
    end else begin
      st_q        <= st_d;
      rsp_valid_q <= respond;
      if (accept) begin
        pend_ops_q <= req_ops_i[g_idx*OPW +: OPW];
        pend_id_q  <= g_idx;
      end
      if (respond) begin
        rsp_hit_q <= l_any;
        rsp_res_q <= l_any ? l_res : '0;
        rsp_id_q  <= pend_id_q;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_res_o   = rsp_res_q;
  assign rsp_id_o    = rsp_id_q;
endmodule

// File: rtl/memo_cache_chk.sv
module memo_cache_chk #(
  parameter int NUM_REQ = 4,
  parameter int NUM_OPS = 4,
  parameter int DATA_W  = 16,
  localparam int RW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int AW = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_commut_i,
  input logic [AW-1:0]      cfg_arity_i,
  input logic [NUM_REQ-1:0] req_valid_i,
  input logic [NUM_REQ-1:0] req_ready_o,
  input logic               rsp_valid_o,
  input logic               rsp_hit_o,
  input logic [DATA_W-1:0]  rsp_res_o,
  input logic [RW-1:0]      rsp_id_o
);
  logic          acc, swp_cfg;
  logic [RW-1:0] acc_id, last_id_q;

  assign acc     = |req_ready_o;
  assign swp_cfg = cfg_commut_i && (cfg_arity_i == AW'(1));

  always_comb begin
    acc_id = '0;
    for (int i = 0; i < NUM_REQ; i++) if (req_ready_o[i]) acc_id = RW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_id_q <= '0;
    else if (acc) last_id_q <= acc_id;
  end

  assert_gnt_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));
  assert_gnt_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);
  assert_fwd_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !swp_cfg) |-> ##2 rsp_valid_o);
  assert_rsp_not_early_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !rsp_valid_o);
  assert_rsp_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_miss_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> rsp_res_o == '0);
  assert_rsp_id_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_id_o == last_id_q);
  assert_busy_no_gnt_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> req_ready_o == '0);
endmodule

bind memo_cache memo_cache_chk #(
  .NUM_REQ (NUM_REQ),
  .NUM_OPS (NUM_OPS),
  .DATA_W  (DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_commut_i (cfg_commut_i),
  .cfg_arity_i  (cfg_arity_i),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_hit_o    (rsp_hit_o),
  .rsp_res_o    (rsp_res_o),
  .rsp_id_o     (rsp_id_o)
);

// File: tb/tb_memo_cache.sv
module tb_memo_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NR  = 4;
  localparam int NO  = 4;
  localparam int DW  = 16;
  localparam int NE  = 8;
  localparam int OPW = NO * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_commut = 1'b0;
  logic [1:0] cfg_arity = 2'd1;
  logic [NR-1:0] req_valid = '0;
  logic [NR*OPW-1:0] req_ops = '0;
  logic [NR-1:0] req_ready;
  logic rsp_valid, rsp_hit;
  logic [DW-1:0] rsp_res;
  logic [1:0] rsp_id;
  logic upd_valid = 1'b0;
  logic [OPW-1:0] upd_ops = '0;
  logic [DW-1:0] upd_res = '0;

  memo_cache #(.NUM_REQ(NR), .NUM_OPS(NO), .DATA_W(DW), .NUM_ENT(NE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_commut_i(cfg_commut), .cfg_arity_i(cfg_arity),
    .req_valid_i(req_valid), .req_ops_i(req_ops), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_res_o(rsp_res), .rsp_id_o(rsp_id),
    .upd_valid_i(upd_valid), .upd_ops_i(upd_ops), .upd_res_i(upd_res)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int id;
    bit hit;
    logic [DW-1:0] res;
    int due;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int cyc = 0;
  int errs = 0;
  int checks = 0;
  int last_id = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [OPW-1:0] pk(int a, int b, int c = 0, int d = 0);
    return {DW'(d), DW'(c), DW'(b), DW'(a)};
  endfunction

  task automatic chk(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        checks++;
        if (sb.size() == 0) begin
          errs++;
          $display("FAIL R3: unexpected response id=%0d expected none", rsp_id);
        end else begin
          cur = sb.pop_front();
          if (rsp_hit !== cur.hit || rsp_res !== cur.res || int'(rsp_id) != cur.id || cyc != cur.due) begin
            errs++;
            $display("FAIL %s: hit=%0b res=%0d id=%0d cyc=%0d expected hit=%0b res=%0d id=%0d cyc=%0d",
                     cur.tag, rsp_hit, rsp_res, rsp_id, cyc, cur.hit, cur.res, cur.id, cur.due);
          end
        end
      end else if (sb.size() != 0 && cyc > sb[0].due) begin
        checks++;
        errs++;
        cur = sb.pop_front();
        $display("FAIL %s: no response at cyc=%0d expected cyc=%0d", cur.tag, cyc, cur.due);
      end
    end
  end

  task automatic lookup(int id, logic [OPW-1:0] ops, bit eh, int er, int lat, string tag);
    exp_t e;
    @(negedge clk);
    req_valid[id] = 1'b1;
    req_ops[id*OPW +: OPW] = ops;
    #1;
    while (!req_ready[id]) begin
      @(negedge clk);
      #1;
    end
    e.id = id; e.hit = eh; e.res = DW'(er); e.due = cyc + lat; e.tag = tag;
    sb.push_back(e);
    last_id = id;
    @(posedge clk);
    #1;
    req_valid[id] = 1'b0;
  endtask

  task automatic update(logic [OPW-1:0] ops, int res);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_ops = ops;
    upd_res = DW'(res);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(bit c, int ar);
    drain();
    cfg_commut = c;
    cfg_arity = 2'(ar);
  endtask

  // all requesters at once: rotating grant order and requester ids
  task automatic contend();
    exp_t e;
    int nxt;
    nxt = (last_id + 1) % NR;
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      req_ops[i*OPW +: OPW] = pk(10 + i, 20);
      req_valid[i] = 1'b1;
    end
    for (int n = 0; n < NR; n++) begin
      #1;
      while (req_ready == '0) begin
        @(negedge clk);
        #1;
      end
      chk("R2 grant order", req_ready == NR'(1 << nxt), int'(req_ready), 1 << nxt);
      e.id = nxt; e.hit = 1'b1; e.res = DW'(300 + nxt); e.due = cyc + 2; e.tag = "R12";
      sb.push_back(e);
      @(posedge clk);
      #1;
      req_valid[nxt] = 1'b0;
      @(negedge clk);
      #1;
      chk("R13 no grant in flight", req_ready == '0, int'(req_ready), 0);
      nxt = (nxt + 1) % NR;
      @(negedge clk);
    end
    last_id = (nxt + NR - 1) % NR;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", rsp_valid == 1'b0, int'(rsp_valid), 0);
    chk("R1 ready in reset", req_ready == '0, int'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", rsp_valid == 1'b0, int'(rsp_valid), 0);

    lookup(0, pk(1, 2), 0, 0, 2, "R1 empty store miss");
    update(pk(3, 5), 100);
    lookup(0, pk(3, 5), 1, 100, 2, "R3");
    lookup(1, pk(5, 3), 0, 0, 2, "R8");
    lookup(2, pk(3, 5, 77, 88), 1, 100, 2, "R5");

    set_cfg(1, 1);
    lookup(3, pk(5, 3), 1, 100, 3, "R6 swapped hit");
    lookup(0, pk(3, 5), 1, 100, 2, "R6 direct hit");
    lookup(1, pk(9, 9), 0, 0, 3, "R6 swapped miss R4");
    lookup(2, pk(3, 5, 1, 1), 1, 100, 2, "R5 commutative");

    set_cfg(1, 2);
    update(pk(1, 2, 3), 7);
    lookup(3, pk(1, 2, 3), 1, 7, 2, "R7 hit");
    lookup(0, pk(2, 1, 3), 0, 0, 2, "R7 no swap");
    lookup(1, pk(1, 2, 4), 0, 0, 2, "R5 third operand");

    set_cfg(1, 1);
    update(pk(5, 3), 200);
    lookup(1, pk(3, 5), 1, 200, 3, "R10");

    set_cfg(0, 2);
    update(pk(1, 2, 3), 8);
    lookup(2, pk(1, 2, 3), 1, 8, 2, "R9");

    set_cfg(0, 1);
    for (int i = 0; i < 6; i++) update(pk(10 + i, 20), 300 + i);
    lookup(3, pk(5, 3), 1, 200, 2, "R9 no duplicate slot");
    lookup(0, pk(1, 2), 1, 8, 2, "R9 no duplicate slot");
    lookup(1, pk(15, 20), 1, 305, 2, "R11 full");
    update(pk(50, 60), 999);
    lookup(2, pk(5, 3), 0, 0, 2, "R11 oldest evicted");
    lookup(3, pk(50, 60), 1, 999, 2, "R11 new entry");
    lookup(0, pk(1, 2), 1, 8, 2, "R11 second kept");
    update(pk(51, 60), 998);
    lookup(1, pk(1, 2), 0, 0, 2, "R11 second evicted");
    lookup(2, pk(51, 60), 1, 998, 2, "R11 new entry");

    drain();
    contend();
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule